// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Instruction Sequencer

This block sequences instruction fetch for a small microcontroller core that keeps its program in a memory separate from its data. It divides the input clock into machine cycles of four phases. In every machine cycle it presents one program counter value to a program memory that is 14 bits wide, and it captures the whole instruction word in a single read. The word fetched during one machine cycle executes during the next one. The fetch of the following word overlaps that execution, so one instruction completes per machine cycle.

An external decoder watches the instruction that is executing. It reports a control transfer (a jump or call with an 11-bit target) or a skip. In both cases the sequencer discards the word it has already prefetched and replaces it with an empty slot. For one machine cycle that slot shows an all-zero instruction with the valid flag low. A transfer also loads the target into the program counter. A skip lets fetching carry on at the next address. Right after reset the program counter is zero, and the first machine cycle only fetches.

Top module: `isq_sequencer`

## Requirements
- R1: The `phase` output is one-hot and rotates bit 0, bit 1, bit 2, bit 3, then back to bit 0, advancing on every clock. Bit 0 marks phase 1 and bit 3 marks phase 4, so a machine cycle is four clocks long.
- R2: In the cycle after a synchronous reset, `phase` is 4'b0001, `pmem_addr` is 0, `instr` is 0 and `instr_valid` is 0. This holds whatever the block was doing when reset arrived.
- R3: `pmem_addr` stays constant through all four phases of a machine cycle. It changes only on the clock edge that ends phase 4.
- R4: With no accepted request, the program counter advances by one per machine cycle. On the edge that ends phase 4, `instr` is loaded with the `pmem_rdata` word read from the current address, and `instr_valid` goes to 1 for the following machine cycle.
- R5: A `xfer_req` that is high on the edge ending phase 4 while `instr_valid` is 1 loads `xfer_target` into the program counter, zero-extended to the counter width. The next machine cycle shows `instr` = 0 and `instr_valid` = 0. The word at the target executes in the machine cycle after that.
- R6: A `skip_req` that is accepted under the same conditions also discards the prefetched word: `instr` = 0 and `instr_valid` = 0 for one machine cycle. The program counter still advances by one.
- R7: When `xfer_req` and `skip_req` are both accepted on the same edge, the transfer wins and the program counter loads the target.
- R8: Requests are ignored in a machine cycle whose `instr_valid` is 0. This covers the first cycle after reset and any flushed slot.
- R9: Requests are sampled only on the edge that ends phase 4. A request that is high during phases 1 to 3 and low on that edge has no effect.
- R10: The program counter wraps from its all-ones value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| phase | output | 4 | One-hot phase of the current machine cycle (bit 0 = phase 1) |
| pmem_addr | output | 13 | Program memory fetch address (program counter) |
| pmem_rdata | input | 14 | Instruction word read from the program memory |
| xfer_req | input | 1 | Decoded jump/call request from the executing instruction |
| xfer_target | input | 11 | Jump/call target address |
| skip_req | input | 1 | Decoded skip request from the executing instruction |
| instr | output | 14 | Instruction register; all zeros in a flushed slot |
| instr_valid | output | 1 | High when `instr` holds a word to execute |

## Verification
A table of machine-cycle vectors runs the sequencer through four kinds of traffic: plain sequential flow, accepted transfers (including the largest and the zero target), accepted skips, and a transfer and a skip raised together. The plain flow checks that each word executes one cycle after it is fetched. The transfer and skip vectors show that the prefetched word is discarded and tell apart a reload of the program counter from a plain increment. The combined vector shows which of the two requests has priority. The same table raises requests in the fetch-only cycle and in flushed slots, which shows that such cycles cannot redirect the fetch. Directed runs add the following: a request dropped just before the phase-4 edge, a reset in the middle of a cycle, and a long stretch of plain flow that carries the program counter through its wrap to zero.

// File: rtl/isq_pkg.sv
package isq_pkg;
  // Width of one program-memory word.
  localparam int unsigned WORD_W = 14;
  // Word executed in a discarded slot.
  localparam logic [WORD_W-1:0] EMPTY_WORD = '0;
endpackage

// File: rtl/isq_phase_gen.sv
module isq_phase_gen #(
  parameter int unsigned NUM_PH = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [NUM_PH-1:0] phase_oh,
  output logic              cyc_end
);
  localparam int unsigned PH_W = (NUM_PH > 1) ? $clog2(NUM_PH) : 1;
  localparam logic [PH_W-1:0] LAST_IDX = PH_W'(NUM_PH - 1);

  logic [PH_W-1:0] ph_cnt;

  // Phase index counter; its terminal value marks the end of the machine cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_cnt <= '0;
    end else if (ph_cnt == LAST_IDX) begin
      ph_cnt <= '0;
    end else begin
      ph_cnt <= ph_cnt + 1'b1;
    end
  end

  // Rotating one-hot phase output, registered.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_oh <= NUM_PH'(1);
    end else begin
      phase_oh <= {phase_oh[NUM_PH-2:0], phase_oh[NUM_PH-1]};
    end
  end

  assign cyc_end = (ph_cnt == LAST_IDX);

  assert_phase_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_oh) == 1);

  assert_phase_agree_R1: assert property (@(posedge clk) disable iff (rst)
    cyc_end == phase_oh[NUM_PH-1]);
endmodule

// File: rtl/isq_pc_unit.sv
module isq_pc_unit #(
  parameter int unsigned PC_W  = 13,
  parameter int unsigned TGT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_end,
  input  logic             take_xfer,
  input  logic [TGT_W-1:0] xfer_target,
  output logic [PC_W-1:0]  pc
);
  logic [PC_W-1:0] tgt_ext;

  // Fit the target to the counter width: zero-extend or truncate.
  generate
    if (PC_W > TGT_W) begin : g_ext
      assign tgt_ext = {{(PC_W-TGT_W){1'b0}}, xfer_target};
    end else begin : g_trunc
      assign tgt_ext = xfer_target[PC_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else if (cyc_end) begin
      if (take_xfer) begin
        pc <= tgt_ext;
      end else begin
        pc <= pc + 1'b1;
      end
    end
  end

  assert_pc_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !cyc_end |=> $stable(pc));

  assert_pc_load_R5: assert property (@(posedge clk) disable iff (rst)
    cyc_end && take_xfer |=> pc == $past(tgt_ext));

  assert_pc_step_R4: assert property (@(posedge clk) disable iff (rst)
    cyc_end && !take_xfer |=> pc == PC_W'($past(pc) + 1'b1));
endmodule

// File: rtl/isq_fetch_reg.sv
module isq_fetch_reg
  import isq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_end,
  input  logic [WORD_W-1:0] pmem_rdata,
  input  logic              xfer_req,
  input  logic              skip_req,
  output logic [WORD_W-1:0] instr,
  output logic              instr_valid,
  output logic              take_xfer
);
  logic flush;

  // Only a live instruction may redirect the fetch stream.
  assign flush     = instr_valid && (xfer_req || skip_req);
  assign take_xfer = cyc_end && instr_valid && xfer_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      instr       <= EMPTY_WORD;
      instr_valid <= 1'b0;
    end else if (cyc_end) begin
      if (flush) begin
        instr       <= EMPTY_WORD;
        instr_valid <= 1'b0;
      end else begin
        instr       <= pmem_rdata;
        instr_valid <= 1'b1;
      end
    end
  end

  assert_flush_empty_R6: assert property (@(posedge clk) disable iff (rst)
    cyc_end && instr_valid && (xfer_req || skip_req) |=> !instr_valid && instr == EMPTY_WORD);

  assert_ir_capture_R4: assert property (@(posedge clk) disable iff (rst)
    cyc_end && !(instr_valid && (xfer_req || skip_req)) |=> instr_valid && instr == $past(pmem_rdata));

  assert_ir_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !cyc_end |=> $stable(instr) && $stable(instr_valid));
endmodule

// File: rtl/isq_sequencer.sv
module isq_sequencer
  import isq_pkg::*;
#(
  parameter int unsigned PC_W   = 13,
  parameter int unsigned TGT_W  = 11,
  parameter int unsigned NUM_PH = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [NUM_PH-1:0] phase,
  output logic [PC_W-1:0]   pmem_addr,
  input  logic [WORD_W-1:0] pmem_rdata,
  input  logic              xfer_req,
  input  logic [TGT_W-1:0]  xfer_target,
  input  logic              skip_req,
  output logic [WORD_W-1:0] instr,
  output logic              instr_valid
);
  logic cyc_end;
  logic take_xfer;

  isq_phase_gen #(.NUM_PH(NUM_PH)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .phase_oh (phase),
    .cyc_end  (cyc_end)
  );

  isq_fetch_reg u_fetch (
    .clk         (clk),
    .rst         (rst),
    .cyc_end     (cyc_end),
    .pmem_rdata  (pmem_rdata),
    .xfer_req    (xfer_req),
    .skip_req    (skip_req),
    .instr       (instr),
    .instr_valid (instr_valid),
    .take_xfer   (take_xfer)
  );

  isq_pc_unit #(.PC_W(PC_W), .TGT_W(TGT_W)) u_pc (
    .clk         (clk),
    .rst         (rst),
    .cyc_end     (cyc_end),
    .take_xfer   (take_xfer),
    .xfer_target (xfer_target),
    .pc          (pmem_addr)
  );

  // A flushed slot cannot start another flush in the following cycle.
  assert_empty_slot_inert_R8: assert property (@(posedge clk) disable iff (rst)
    phase[NUM_PH-1] && !instr_valid |=> instr_valid);
endmodule

// File: tb/isq_sequencer_test.sv
module isq_sequencer_test;
  localparam int PC_W  = 13;
  localparam int TGT_W = 11;

  typedef struct packed {
    logic             x;
    logic             s;
    logic [TGT_W-1:0] t;
  } vec_t;

  // One entry per machine cycle, starting with the fetch-only cycle after reset.
  localparam vec_t VECS [0:15] = '{
    '{1'b1, 1'b0, 11'h055},  // fetch-only cycle: ignored (R8)
    '{1'b0, 1'b0, 11'h000},
    '{1'b0, 1'b0, 11'h000},
    '{1'b1, 1'b0, 11'h123},  // transfer (R5)
    '{1'b1, 1'b0, 11'h400},  // flushed slot: ignored (R8)
    '{1'b0, 1'b0, 11'h000},
    '{1'b0, 1'b1, 11'h000},  // skip (R6)
    '{1'b0, 1'b1, 11'h000},  // flushed slot: ignored (R8)
    '{1'b0, 1'b0, 11'h000},
    '{1'b1, 1'b1, 11'h7FF},  // both: transfer wins (R7)
    '{1'b0, 1'b0, 11'h000},
    '{1'b0, 1'b0, 11'h000},
    '{1'b1, 1'b0, 11'h000},  // transfer to zero (R5)
    '{1'b0, 1'b0, 11'h000},
    '{1'b0, 1'b1, 11'h000},
    '{1'b0, 1'b0, 11'h000}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [3:0]       phase;
  logic [PC_W-1:0]  pmem_addr;
  logic [13:0]      pmem_rdata;
  logic             xfer_req = 1'b0;
  logic [TGT_W-1:0] xfer_target = '0;
  logic             skip_req = 1'b0;
  logic [13:0]      instr;
  logic             instr_valid;

  int n_run  = 0;
  int n_fail = 0;

  logic [PC_W-1:0] exp_pc;
  logic [13:0]     exp_ir;
  logic            exp_v;
  string           tag;

  always #4 clk = ~clk;

  function automatic logic [13:0] word_at(input logic [PC_W-1:0] a);
    return 14'(({1'b0, a} * 14'd37) + 14'd5);
  endfunction

  assign pmem_rdata = word_at(pmem_addr);

  isq_sequencer uut (
    .clk         (clk),
    .rst         (rst),
    .phase       (phase),
    .pmem_addr   (pmem_addr),
    .pmem_rdata  (pmem_rdata),
    .xfer_req    (xfer_req),
    .xfer_target (xfer_target),
    .skip_req    (skip_req),
    .instr       (instr),
    .instr_valid (instr_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a falling edge in phase 1; returns at the falling edge in the next phase 1.
  task automatic mcycle(input logic x, input logic s, input logic [TGT_W-1:0] t, input bit gate_only);
    for (int i = 0; i < 4; i++) begin
      chk("R1", 32'(phase), 32'(4'b0001 << i));
      chk("R3", 32'(pmem_addr), 32'(exp_pc));
      if (i == 0) begin
        chk(tag, 32'(instr), 32'(exp_ir));
        chk(tag, 32'(instr_valid), 32'(exp_v));
        xfer_req = x; skip_req = s; xfer_target = t;
      end
      if (i == 3 && gate_only) begin
        xfer_req = 1'b0; skip_req = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
    end
    xfer_req = 1'b0; skip_req = 1'b0;
    if (gate_only) begin
      tag = "R9";
      exp_ir = word_at(exp_pc); exp_v = 1'b1; exp_pc = exp_pc + 1'b1;
    end else if (exp_v && x) begin
      tag = s ? "R7" : "R5";
      exp_ir = '0; exp_v = 1'b0; exp_pc = PC_W'(t);
    end else if (exp_v && s) begin
      tag = "R6";
      exp_ir = '0; exp_v = 1'b0; exp_pc = exp_pc + 1'b1;
    end else begin
      tag = (x || s) ? "R8" : "R4";
      exp_ir = word_at(exp_pc); exp_v = 1'b1; exp_pc = exp_pc + 1'b1;
      if (exp_pc == '0) tag = "R10";
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_pc = '0; exp_ir = '0; exp_v = 1'b0; tag = "R2";
    chk("R2", 32'(phase), 32'h1);
    chk("R2", 32'(pmem_addr), 32'h0);
    chk("R2", 32'(instr), 32'h0);
    chk("R2", 32'(instr_valid), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R4: watchdog, actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    foreach (VECS[k]) mcycle(VECS[k].x, VECS[k].s, VECS[k].t, 1'b0);
    repeat (2) mcycle(1'b0, 1'b0, '0, 1'b0);

    // R9: request raised in phases 1-3, dropped before the phase-4 edge.
    mcycle(1'b1, 1'b1, 11'h2AA, 1'b1);
    mcycle(1'b0, 1'b0, '0, 1'b0);
    mcycle(1'b0, 1'b0, '0, 1'b0);

    // R2: reset in the middle of a machine cycle.
    @(negedge clk);
    @(negedge clk);
    do_reset();
    repeat (3) mcycle(1'b0, 1'b0, '0, 1'b0);

    // R10: sequential flow past the top of the address space.
    for (int k = 0; k < (1 << PC_W) + 2; k++) mcycle(1'b0, 1'b0, '0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule